// File: doc/BRIEF.md
# Four-Channel Bus Arbiter with Selectable Rotation

This block decides which of four DMA channels may drive a shared on-chip bus. Each channel holds a request line high while it wants the bus. When the bus is free, the arbiter picks one requester and registers a one-hot grant. It keeps that grant until the owning channel pulses `xfer_done`.

A live mode input chooses how requests are ranked. With the mode low, the ranking is strict: channel 0 first and channel 3 last. With the mode high, the ranking rotates so that the channel that most recently finished a transfer goes to the back of the queue. The arbiter always records which channel finished last, in either mode. A change of mode therefore acts on real history at once.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While `rst_n` is low, `grant` is 4'b0000 and `grant_vld` is 0.
- R2: When the bus is idle and no channel requests, `grant` stays all zeros and `grant_vld` stays 0.
- R3: When the bus is idle and `rotate_mode` is 0, the next clock edge grants the requesting channel with the lowest index. Bit i of `grant` and of `req` stands for channel i.
- R4: When `rotate_mode` is 1, the search starts one channel above the last completed channel and wraps around. After channel 0 completes, the order is 1,2,3,0. After channel 1 it is 2,3,0,1. After channel 2 it is 3,0,1,2. After channel 3 it is 0,1,2,3.
- R5: After reset, the last-completed channel is taken to be channel 3. The first rotating arbitration therefore uses the order 0,1,2,3.
- R6: While a grant is held and `xfer_done` is low, `grant` does not change, whatever the requests or the mode do.
- R7: `grant` has at most one bit set, and `grant_vld` is 1 exactly when `grant` is nonzero.
- R8: A `xfer_done` pulse while no grant is held has no effect on the grant or on the rotation history.
- R9: On the edge where `xfer_done` is seen with a grant held, the grant is released. `grant_vld` is 0 for the following cycle, and a new grant is registered on the edge after that.
- R10: Completions also update the rotation history while `rotate_mode` is 0. A later switch to rotating mode ranks channels after the channel that completed last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rotate_mode | input | 1 | 0 = strict priority, 1 = last-completed-lowest rotation |
| req | input | 4 | Per-channel bus request, bit i = channel i |
| xfer_done | input | 1 | One-cycle pulse: the current owner finished its transfer |
| grant | output | 4 | One-hot bus grant, bit i = channel i |
| grant_vld | output | 1 | High while a grant is held |

## Verification
The only hidden state is the last-completed pointer and the held grant. A wrong grant register shows up at the ports on the very next cycle, as a second bit, a grant that moves without a done pulse, or a missing idle gap. A corrupted pointer stays invisible until the next rotating arbitration with several channels requesting at once. The tests therefore finish a known channel and then contest the bus with a chosen set of requests, in both modes and after a mode switch. This makes the pointer show up within two cycles.

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rotate_mode,
  input  logic [NCH-1:0] req,
  input  logic           xfer_done,
  output logic [NCH-1:0] grant,
  output logic           grant_vld
);

  logic [NCH-1:0] grant_q, pick;
  logic [IW-1:0]  last_q, owner, base;
  logic           busy;

  assign busy      = |grant_q;
  assign grant     = grant_q;
  assign grant_vld = busy;

  always_comb begin
    owner = '0;
    for (int i = 0; i < NCH; i++)
      if (grant_q[i]) owner = IW'(i);
  end

  assign base = !rotate_mode ? '0 :
                (last_q == IW'(NCH-1)) ? '0 : last_q + 1'b1;

  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NCH; k++) begin
      int idx;
      idx = (int'(base) + k) % NCH;
      if (!found && req[idx]) begin
        pick[idx] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      last_q  <= IW'(NCH-1);
    end else if (busy) begin
      if (xfer_done) begin
        grant_q <= '0;
        last_q  <= owner;
      end
    end else begin
      grant_q <= pick;
    end
  end

  // R7
  onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R6
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && !xfer_done) |=> $stable(grant));

  // R9
  release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && xfer_done) |=> !grant_vld);

  // R2
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld && req == '0) |=> !grant_vld);

  // R3
  fixed_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld && !rotate_mode && req != '0) |=>
      grant == ($past(req) & (~$past(req) + 1'b1)));

  // R4
  grant_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld && req != '0) |=> (grant & $past(req)) != '0);

endmodule

// File: tb/test_dma_bus_arbiter.sv
`timescale 1ns/1ps
module test_dma_bus_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rotate_mode = 1'b0;
  logic [3:0] req = '0;
  logic       xfer_done = 1'b0;
  logic [3:0] grant;
  logic       grant_vld;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  dma_bus_arbiter i_dma_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .rotate_mode(rotate_mode), .req(req),
    .xfer_done(xfer_done), .grant(grant), .grant_vld(grant_vld));

  task automatic check(string tag, logic [3:0] exp_g);
    total++;
    if (grant !== exp_g || grant_vld !== (exp_g != 0)) begin
      bad++;
      $display("FAIL %s: grant=%b vld=%b expected grant=%b vld=%b",
               tag, grant, grant_vld, exp_g, exp_g != 0);
    end
    total++;
    if (!$onehot0(grant) || grant_vld !== (grant != 0)) begin
      bad++;
      $display("FAIL R7 (%s): grant=%b vld=%b expected one-hot with matching vld",
               tag, grant, grant_vld);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_xfer(logic [3:0] new_req);
    xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    req = new_req;
    check("R9 gap after done", 4'b0000);
    tick();
  endtask

  task automatic t_reset;
    req = 4'b1111;
    tick(2);
    check("R1 reset", 4'b0000);
    req = '0;
    rst_n = 1'b1;
    tick(3);
    check("R2 idle", 4'b0000);
  endtask

  task automatic t_first_rotate;
    xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    check("R8 done while idle", 4'b0000);
    rotate_mode = 1'b1;
    req = 4'b1111;
    tick();
    check("R5 first rotating order", 4'b0001);
    finish_xfer(4'b0000);
    check("R2 idle after done", 4'b0000);
  endtask

  task automatic t_fixed;
    rotate_mode = 1'b0;
    req = 4'b1100;
    tick();
    check("R3 fixed 1100", 4'b0100);
    finish_xfer(4'b1000);
    check("R3 fixed 1000", 4'b1000);
    finish_xfer(4'b1010);
    check("R3 fixed 1010", 4'b0010);
    finish_xfer(4'b0000);
  endtask

  task automatic t_hold;
    rotate_mode = 1'b0;
    req = 4'b1000;
    tick();
    check("R6 grant 3", 4'b1000);
    req = 4'b1001;
    tick(2);
    check("R6 hold vs higher", 4'b1000);
    rotate_mode = 1'b1;
    req = 4'b0000;
    tick(2);
    check("R6 hold vs mode/req", 4'b1000);
    finish_xfer(4'b0000);
  endtask

  task automatic t_rotate;
    rotate_mode = 1'b1;
    req = 4'b0010;
    tick();
    check("R4 grant 1", 4'b0010);
    finish_xfer(4'b1001);
    check("R4 after 1", 4'b1000);
    finish_xfer(4'b0101);
    check("R4 after 3", 4'b0001);
    finish_xfer(4'b1100);
    check("R4 after 0", 4'b0100);
    finish_xfer(4'b1111);
    for (int n = 0; n < 5; n++) begin
      logic [3:0] e;
      e = 4'b0001 << ((3 + n) % 4);
      check("R4 full rotation", e);
      finish_xfer(4'b1111);
    end
    finish_xfer(4'b0000);
  endtask

  task automatic t_history;
    rotate_mode = 1'b0;
    req = 4'b0100;
    tick();
    check("R10 fixed grant 2", 4'b0100);
    finish_xfer(4'b0000);
    rotate_mode = 1'b1;
    req = 4'b1010;
    tick();
    check("R10 history after switch", 4'b1000);
    finish_xfer(4'b0000);
  endtask

  initial begin
    tick();
    t_reset();
    t_first_rotate();
    t_fixed();
    t_hold();
    t_rotate();
    t_history();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule